// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block drives a pulse-width modulated signal for a panel backlight. It runs on a reference clock and is set up through a small byte-wide register port. An 8-bit pre-divider stretches every step of a 16-bit period counter. A 16-bit scale value sets where that counter wraps, and a 16-bit compare value sets where the output drops within each period. Two control bits switch the waveform on and flip its polarity.

Inside, two counters are nested. A prescaler counts reference clocks and, each time it reaches the pre-divider value, moves the period counter on by one. The period counter climbs from zero to the scale value. It spends one reference clock at the scale value and then returns to zero. The output is active from the wrap until the period counter reaches the compare value. One period therefore lasts pre-divider × scale + 1 reference clocks.

Software loads the 16-bit values one byte at a time, so a period may briefly mix old and new settings. Reads return the stored fields at once through a combinational path.

Top module: `backlight_pwm`

## Requirements
- R1: After reset every register reads 0x00 and `pwmOut` is low.
- R2: Byte address 0xA0 holds the pre-divider. 0xA1 and 0xA2 hold the scale, low byte first. 0xA3 and 0xA4 hold the compare value, low byte first. 0xA5 holds control, with bit 1 as enable and bit 0 as invert. A read returns the last value written to that address, and control bits 7..2 read as zero.
- R3: Any address outside 0xA0..0xA5 reads 0x00, and a write to it changes no register.
- R4: While enabled, the active level of the output repeats every PRE×SCALE+1 reference clocks, where PRE is the pre-divider and SCALE is the scale value.
- R5: For 1 ≤ COMPARE ≤ SCALE, the output is active for COMPARE×PRE clocks of each period, starting at the wrap.
- R6: A COMPARE value greater than SCALE keeps the output active for the whole period. A COMPARE of zero keeps it inactive.
- R7: A pre-divider of zero behaves exactly like a pre-divider of one.
- R8: With invert set, the pin is the complement of the non-inverted waveform, so the active level is low.
- R9: While enable is clear, both counters stay at zero and `pwmOut` equals the invert bit.
- R10: When enable changes from 0 to 1, a new period starts at the next clock. The output is active right away and stays active for COMPARE×PRE clocks.
- R11: The period counter moves only by +1 on a prescaler wrap, or returns to zero after its one-clock stay at SCALE. At most one of clear, step and wrap happens in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| pwmOut | output | 1 | PWM output pin |

## Verification
Period and active time are measured for several sets of pre-divider, scale and compare values, chosen so that a wrong product, a missing "+1" or an off-by-one compare each give a different count. One set has the compare value equal to the scale, to expose the single-clock tail of each period. Another uses a pre-divider of zero, to tell the divide-by-one case apart from a stalled prescaler. Constant-level cases (compare above scale, compare of zero), both polarities while disabled, and the first pulse after enabling cover the edges of the comparator and the restart logic. Reads at mapped and unmapped addresses confirm the byte split and that stray writes are ignored.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  localparam int PD_W   = 8;
  localparam int SC_W   = 16;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_PD     = 8'hA0;
  localparam logic [ADDR_W-1:0] ADR_SCL_LO = ADR_PD + 8'd1;
  localparam logic [ADDR_W-1:0] ADR_SCL_HI = ADR_PD + 8'd2;
  localparam logic [ADDR_W-1:0] ADR_CMP_LO = ADR_PD + 8'd3;
  localparam logic [ADDR_W-1:0] ADR_CMP_HI = ADR_PD + 8'd4;
  localparam logic [ADDR_W-1:0] ADR_CTL    = ADR_PD + 8'd5;

  localparam int CTL_EN_BIT  = 1;
  localparam int CTL_INV_BIT = 0;

  typedef struct packed {
    logic [PD_W-1:0] preDiv;
    logic [SC_W-1:0] scale;
    logic [SC_W-1:0] compare;
    logic            enable;
    logic            invert;
  } pwmCfg_t;

  typedef struct packed {
    logic clear;
    logic step;
    logic wrap;
  } cntStrobe_t;
endpackage

// File: rtl/bpwm_regs.sv
module bpwm_regs
  import bpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output pwmCfg_t           cfg
);
  pwmCfg_t cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (wrEn) begin
      case (addr)
        ADR_PD:     cfgQ.preDiv        <= wrData;
        ADR_SCL_LO: cfgQ.scale[7:0]    <= wrData;
        ADR_SCL_HI: cfgQ.scale[15:8]   <= wrData;
        ADR_CMP_LO: cfgQ.compare[7:0]  <= wrData;
        ADR_CMP_HI: cfgQ.compare[15:8] <= wrData;
        ADR_CTL: begin
          cfgQ.enable <= wrData[CTL_EN_BIT];
          cfgQ.invert <= wrData[CTL_INV_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADR_PD:     rdData = cfgQ.preDiv;
      ADR_SCL_LO: rdData = cfgQ.scale[7:0];
      ADR_SCL_HI: rdData = cfgQ.scale[15:8];
      ADR_CMP_LO: rdData = cfgQ.compare[7:0];
      ADR_CMP_HI: rdData = cfgQ.compare[15:8];
      ADR_CTL: begin
        rdData[CTL_EN_BIT]  = cfgQ.enable;
        rdData[CTL_INV_BIT] = cfgQ.invert;
      end
      default: rdData = '0;
    endcase
  end

  assign cfg = cfgQ;
endmodule

// File: rtl/bpwm_ctrl.sv
module bpwm_ctrl
  import bpwm_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic [PD_W-1:0] preDiv,
  input  logic            atEnd,
  output cntStrobe_t      stb
);
  logic [PD_W-1:0] cntA;
  logic [PD_W-1:0] pdEff;
  logic            lastA;

  // A pre-divider of zero is promoted to one so the prescaler never stalls.
  assign pdEff = (preDiv == '0) ? PD_W'(1) : preDiv;
  assign lastA = (cntA >= pdEff - PD_W'(1));

  always_comb begin
    stb.clear = !enable;
    stb.wrap  = enable && atEnd;
    stb.step  = enable && !atEnd && lastA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntA <= '0;
    end else if (stb.clear || stb.wrap || stb.step) begin
      cntA <= '0;
    end else begin
      cntA <= cntA + PD_W'(1);
    end
  end
endmodule

// File: rtl/bpwm_datapath.sv
module bpwm_datapath
  import bpwm_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  cntStrobe_t      stb,
  input  logic            enable,
  input  logic            invert,
  input  logic [SC_W-1:0] scale,
  input  logic [SC_W-1:0] compare,
  output logic            atEnd,
  output logic [SC_W-1:0] periodCnt,
  output logic            pwmOut
);
  logic [SC_W-1:0] cntB;
  logic            activeLvl;

  // The last value of the period lasts one reference clock only.
  assign atEnd = (cntB >= scale);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntB <= '0;
    end else if (stb.clear || stb.wrap) begin
      cntB <= '0;
    end else if (stb.step) begin
      cntB <= cntB + SC_W'(1);
    end
  end

  assign activeLvl = (cntB < compare);
  assign pwmOut    = enable ? (activeLvl ^ invert) : invert;
  assign periodCnt = cntB;
endmodule

// File: rtl/backlight_pwm.sv
module backlight_pwm
  import bpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              pwmOut
);
  pwmCfg_t         cfg;
  cntStrobe_t      stb;
  logic            atEnd;
  logic            cfgEn;
  logic [SC_W-1:0] cntB;

  assign cfgEn = cfg.enable;

  bpwm_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr),
    .wrData(regWrData), .rdData(regRdData), .cfg(cfg)
  );

  bpwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(cfg.enable), .preDiv(cfg.preDiv),
    .atEnd(atEnd), .stb(stb)
  );

  bpwm_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .enable(cfg.enable), .invert(cfg.invert),
    .scale(cfg.scale), .compare(cfg.compare), .atEnd(atEnd),
    .periodCnt(cntB), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/bpwm_checker.sv
module bpwm_checker
  import bpwm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              enable,
  input cntStrobe_t        stb,
  input logic [SC_W-1:0]   cntB
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.clear, stb.step, stb.wrap})); // R11

  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> cntB == $past(cntB) + SC_W'(1)); // R11

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrap |=> cntB == '0); // R4

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> cntB == '0); // R9

  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |-> cntB == '0); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr < ADR_PD || regAddr > ADR_CTL) |-> regRdData == '0); // R3
endmodule

bind backlight_pwm bpwm_checker u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .enable(cfgEn), .stb(stb), .cntB(cntB)
);

// File: tb/tb_backlight_pwm.sv
module tb_backlight_pwm;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       pwmOut;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  typedef struct {
    int    period;
    int    high;
    bit    inv;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  backlight_pwm dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input logic [7:0] a, input int exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic setup(input int pd, input int sc, input int bl, input bit inv, input bit en);
    wr(8'hA5, {6'd0, 1'b0, inv});
    wr(8'hA0, pd[7:0]);
    wr(8'hA1, sc[7:0]);
    wr(8'hA2, sc[15:8]);
    wr(8'hA3, bl[7:0]);
    wr(8'hA4, bl[15:8]);
    if (en) wr(8'hA5, {6'd0, 1'b1, inv});
  endtask

  // Driver: configures and pushes the expected measurement into the scoreboard.
  task automatic runCase(input int pd, input int sc, input int bl, input bit inv, input string tag);
    expItem_t it;
    int pe;
    pe = (pd == 0) ? 1 : pd;
    setup(pd, sc, bl, inv, 1'b1);
    it.period = pe * sc + 1;
    it.high   = bl * pe;
    it.inv    = inv;
    it.tag    = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  // Monitor: measures one full active period and compares with the queue head.
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        bit prevL, curL, found;
        int per, hi;
        expItem_t it;
        it = expQ[0];
        prevL = pwmOut ^ it.inv;
        found = 1'b0;
        while (!found) begin
          @(negedge clk);
          curL = pwmOut ^ it.inv;
          found = !prevL && curL;
          prevL = curL;
        end
        per = 1; hi = 1; found = 1'b0;
        while (!found) begin
          @(negedge clk);
          curL = pwmOut ^ it.inv;
          found = !prevL && curL;
          prevL = curL;
          if (!found) begin
            per++;
            hi += int'(curL);
          end
        end
        check({it.tag, " period R4"}, per, it.period);
        check({it.tag, " active R5"}, hi, it.high);
        void'(expQ.pop_front());
      end
    end
  end

  task automatic constLevel(input string tag, input int cycles, input bit lvl);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwmOut != lvl) bad++;
    end
    check(tag, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 8'hA0; a <= 8'hA5; a++) rdCheck("R1 reset read", a[7:0], 0);
    check("R1 reset pwmOut", pwmOut, 0);

    // R2 readback and byte split
    wr(8'hA1, 8'h34); wr(8'hA2, 8'h12);
    wr(8'hA3, 8'hCD); wr(8'hA4, 8'hAB); wr(8'hA0, 8'h07);
    rdCheck("R2 scale lo", 8'hA1, 8'h34);
    rdCheck("R2 scale hi", 8'hA2, 8'h12);
    rdCheck("R2 cmp lo", 8'hA3, 8'hCD);
    rdCheck("R2 cmp hi", 8'hA4, 8'hAB);
    rdCheck("R2 prediv", 8'hA0, 8'h07);
    wr(8'hA5, 8'hFF);
    rdCheck("R2 ctrl bits", 8'hA5, 8'h03);
    wr(8'hA5, 8'h00);

    // R3 unmapped addresses
    wr(8'h9F, 8'h5A); wr(8'hA6, 8'h5A);
    rdCheck("R3 read 9F", 8'h9F, 0);
    rdCheck("R3 read A6", 8'hA6, 0);
    rdCheck("R3 prediv kept", 8'hA0, 8'h07);
    rdCheck("R3 scale kept", 8'hA1, 8'h34);
    rdCheck("R3 ctrl kept", 8'hA5, 8'h00);

    // R4 R5 period and active time, R8 invert, R7 zero pre-divider
    runCase(3, 4, 2, 1'b0, "R4 pd3 sc4 bl2");
    runCase(1, 10, 7, 1'b0, "R4 pd1 sc10 bl7");
    runCase(2, 9, 9, 1'b0, "R5 bl=scale");
    runCase(5, 6, 1, 1'b1, "R8 inv pd5 sc6 bl1");
    runCase(4, 3, 3, 1'b1, "R8 inv pd4 sc3 bl3");
    runCase(0, 7, 3, 1'b0, "R7 pd0 sc7 bl3");
    runCase(1, 7, 3, 1'b0, "R7 pd1 sc7 bl3");

    // R6 constant levels
    setup(2, 5, 6, 1'b0, 1'b1);
    constLevel("R6 compare above scale high", 40, 1'b1);
    setup(2, 5, 0, 1'b0, 1'b1);
    constLevel("R6 compare zero low", 40, 1'b0);

    // R9 disabled output follows invert
    setup(2, 5, 3, 1'b1, 1'b0);
    constLevel("R9 disabled inv=1", 30, 1'b1);
    setup(2, 5, 3, 1'b0, 1'b0);
    constLevel("R9 disabled inv=0", 30, 1'b0);

    // R10 restart on enable: active immediately for bl*pd clocks
    setup(3, 8, 2, 1'b0, 1'b1);
    repeat (7) @(negedge clk);
    wr(8'hA5, 8'h00);
    repeat (3) @(negedge clk);
    begin
      int hi = 0;
      regWrEn = 1'b0;
      @(negedge clk);
      regWrEn = 1'b1; regAddr = 8'hA5; regWrData = 8'h02;
      @(negedge clk);
      regWrEn = 1'b0;
      while (pwmOut && hi < 100) begin
        hi++;
        @(negedge clk);
      end
      check("R10 first pulse length", hi, 6);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule